// File: doc/BRIEF.md
# Session Trigger Engine for Pattern Capture and Playback

This block decides when a digital pattern session begins, when it stops for a while and when it ends. It runs on the sample clock and takes one data-bus sample per cycle. Three triggers control a session. The start and reference triggers react to an edge. The pause trigger reacts to a level. Each trigger takes its condition from one selectable external line, or from a masked comparison of the data bus against a programmed pattern, or it is switched off. A session moves through idle, armed, running, paused and done.

A controller programs the trigger selections, the shared pattern and mask, and the pre- and post-trigger sample counts. It then pulses `arm_i`. The block raises a ready-for-start event while it waits for the start trigger. It raises a data-active event in every cycle in which samples flow. In capture mode, a reference trigger that comes after enough pre-trigger samples starts a post-trigger countdown, and the session ends when the countdown completes. In playback mode, a pause takes effect a fixed number of cycles after the pause condition, and pattern-based sources are not available.

Top module: `trig_engine`

## Requirements
- R1: After reset, `state_o` is 0 (idle), and `ready_start_o` and `data_active_o` are low.
- R2: A high `arm_i` in idle (0) or done (4) moves the session to armed (1) on the next edge. It is ignored in any other state. `ready_start_o` is high exactly while the state is armed.
- R3: In the armed state, a start source of 1 (line) moves the session to running (2) on the edge where the selected line shows a rising edge (polarity 0) or a falling edge (polarity 1) against the previous sample. A start source of 0 (off) moves the session to running on the next edge without waiting.
- R4: The data bus matches when `((data_i ^ pattern_i) & mask_i) == 0`, so bits with a mask bit of 0 are ignored. Source 2 fires when match goes from 0 to 1 between consecutive samples. Source 3 fires when match goes from 1 to 0.
- R5: In playback mode (`gen_mode_i`=1), a pattern source (2 or 3) acts as off. A start trigger set this way does not wait.
- R6: The pause condition is a level: the selected line is high (polarity 0) or low (polarity 1), or the pattern condition of source 2 or 3 holds. In capture mode, running turns to paused (3) on the same edge where the condition is sampled, and it returns to running on the edge where the condition is sampled inactive.
- R7: In playback mode, the running/paused decision at an edge uses the pause condition sampled `PAUSE_LAT` edges earlier.
- R8: `data_active_o` is high exactly while the state is running (2), and low while paused.
- R9: The reference trigger is used only in capture mode. It is accepted only on an edge where the state is running and at least `pre_count_i` running samples have passed since the start. In playback mode it never ends a session.
- R10: After an accepted reference trigger, the session enters done (4) on the `post_count_i`-th later running edge. A count of 0 enters done on the acceptance edge. Paused samples are not counted. Done holds until the session is armed again or stopped.
- R11: A high `stop_i` returns the session to idle on the next edge from any state. It takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm request |
| stop_i | input | 1 | Abort session, back to idle |
| gen_mode_i | input | 1 | 1 = playback session, 0 = capture session |
| lines_i | input | N_LINES | External trigger lines |
| data_i | input | DATA_W | Data bus sample |
| pattern_i | input | DATA_W | Compare pattern |
| mask_i | input | DATA_W | Compare mask, 1 = bit takes part |
| start_src_i | input | 2 | Start source: 0 off, 1 line, 2 match, 3 mismatch |
| start_sel_i | input | SEL_W | Start line index |
| start_pol_i | input | 1 | Start polarity, 0 rising, 1 falling |
| pause_src_i | input | 2 | Pause source, same encoding |
| pause_sel_i | input | SEL_W | Pause line index |
| pause_pol_i | input | 1 | Pause polarity, 0 high active, 1 low active |
| ref_src_i | input | 2 | Reference source, same encoding |
| ref_sel_i | input | SEL_W | Reference line index |
| ref_pol_i | input | 1 | Reference polarity, 0 rising, 1 falling |
| pre_count_i | input | CNT_W | Minimum running samples before reference |
| post_count_i | input | CNT_W | Running samples after reference |
| state_o | output | 3 | 0 idle, 1 armed, 2 running, 3 paused, 4 done |
| ready_start_o | output | 1 | Ready-for-start event |
| data_active_o | output | 1 | Data-active event |

## Verification
The bench builds the block with an 8-bit data bus, four trigger lines, 8-bit counters and `PAUSE_LAT` set to 3. With a latency of 3, the playback pause lag can be checked cycle by cycle without long waits, and it still differs clearly from the capture-mode timing. The 8-bit bus with a half mask shows that masked-off bits do not matter. The small pre- and post-counts let one run place a reference edge both before and after the pre-trigger threshold, with a pause inside the post-trigger window.

// File: rtl/trig_eng_pkg.sv
package trig_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_RUN   = 3'd2,
        ST_PAUSE = 3'd3,
        ST_DONE  = 3'd4
    } sess_t;

    typedef enum logic [1:0] {
        SRC_OFF      = 2'd0,
        SRC_LINE     = 2'd1,
        SRC_MATCH    = 2'd2,
        SRC_MISMATCH = 2'd3
    } src_t;

endpackage

// File: rtl/pat_cmp.sv
module pat_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] pattern_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic              match_o
);
    // only bits selected by the mask take part in the comparison
    always_comb begin
        match_o = (((data_i ^ pattern_i) & mask_i) == '0);
    end
endmodule

// File: rtl/trig_cond.sv
module trig_cond
    import trig_eng_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int SEL_W   = 2,
    parameter bit IS_EDGE = 1'b1
) (
    input  logic [1:0]         src_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               pol_i,
    input  logic               gen_mode_i,
    input  logic [N_LINES-1:0] lines_i,
    input  logic [N_LINES-1:0] lines_prev_i,
    input  logic               match_i,
    input  logic               match_prev_i,
    output logic               fire_o,
    output logic               off_o
);
    src_t src;
    logic lvl_now;
    logic lvl_prev;

    always_comb begin
        src      = src_t'(src_i);
        lvl_now  = 1'b0;
        lvl_prev = 1'b0;
        // pattern sources are unavailable during playback
        off_o    = (src == SRC_OFF) || (gen_mode_i && (src != SRC_LINE));
        case (src)
            SRC_LINE: begin
                lvl_now  = lines_i[sel_i] ^ pol_i;
                lvl_prev = lines_prev_i[sel_i] ^ pol_i;
            end
            SRC_MATCH: begin
                lvl_now  = match_i & ~gen_mode_i;
                lvl_prev = match_prev_i & ~gen_mode_i;
            end
            SRC_MISMATCH: begin
                lvl_now  = ~match_i & ~gen_mode_i;
                lvl_prev = ~match_prev_i & ~gen_mode_i;
            end
            default: begin
                lvl_now  = 1'b0;
                lvl_prev = 1'b0;
            end
        endcase
    end

    generate
        if (IS_EDGE) begin : g_edge
            assign fire_o = lvl_now & ~lvl_prev;
        end else begin : g_level
            assign fire_o = lvl_now;
        end
    endgenerate
endmodule

// File: rtl/pause_delay.sv
module pause_delay #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign out_o = in_i;
        end else begin : g_line
            logic [DEPTH-1:0] pipe_d;
            logic [DEPTH-1:0] pipe_q;

            always_comb begin
                pipe_d = {pipe_q[DEPTH-1:0], in_i} >> 0;
                pipe_d = (DEPTH > 1) ? {pipe_q[(DEPTH>1 ? DEPTH-2 : 0):0], in_i}
                                     : in_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= pipe_d;
            end

            assign out_o = pipe_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/trig_engine.sv
module trig_engine
    import trig_eng_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int N_LINES   = 4,
    parameter int CNT_W     = 16,
    parameter int PAUSE_LAT = 6,
    localparam int SEL_W    = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic               stop_i,
    input  logic               gen_mode_i,
    input  logic [N_LINES-1:0] lines_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [DATA_W-1:0]  pattern_i,
    input  logic [DATA_W-1:0]  mask_i,
    input  logic [1:0]         start_src_i,
    input  logic [SEL_W-1:0]   start_sel_i,
    input  logic               start_pol_i,
    input  logic [1:0]         pause_src_i,
    input  logic [SEL_W-1:0]   pause_sel_i,
    input  logic               pause_pol_i,
    input  logic [1:0]         ref_src_i,
    input  logic [SEL_W-1:0]   ref_sel_i,
    input  logic               ref_pol_i,
    input  logic [CNT_W-1:0]   pre_count_i,
    input  logic [CNT_W-1:0]   post_count_i,
    output logic [2:0]         state_o,
    output logic               ready_start_o,
    output logic               data_active_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        sess_t              st;
        logic [N_LINES-1:0] lines_prev;
        logic               match_prev;
        logic [CNT_W-1:0]   pre;
        logic [CNT_W-1:0]   post;
        logic               ref_seen;
    } eng_t;

    eng_t r_d, r_q;

    logic match;
    logic start_fire, start_off;
    logic pause_fire, pause_off, pause_lvl;
    logic ref_fire, ref_off;
    logic pause_late, pause_eff;

    pat_cmp #(.DATA_W(DATA_W)) u_cmp (
        .data_i    (data_i),
        .pattern_i (pattern_i),
        .mask_i    (mask_i),
        .match_o   (match)
    );

    trig_cond #(.N_LINES(N_LINES), .SEL_W(SEL_W), .IS_EDGE(1'b1)) u_start (
        .src_i(start_src_i), .sel_i(start_sel_i), .pol_i(start_pol_i),
        .gen_mode_i(gen_mode_i), .lines_i(lines_i), .lines_prev_i(r_q.lines_prev),
        .match_i(match), .match_prev_i(r_q.match_prev),
        .fire_o(start_fire), .off_o(start_off)
    );

    trig_cond #(.N_LINES(N_LINES), .SEL_W(SEL_W), .IS_EDGE(1'b0)) u_pause (
        .src_i(pause_src_i), .sel_i(pause_sel_i), .pol_i(pause_pol_i),
        .gen_mode_i(gen_mode_i), .lines_i(lines_i), .lines_prev_i(r_q.lines_prev),
        .match_i(match), .match_prev_i(r_q.match_prev),
        .fire_o(pause_fire), .off_o(pause_off)
    );

    trig_cond #(.N_LINES(N_LINES), .SEL_W(SEL_W), .IS_EDGE(1'b1)) u_ref (
        .src_i(ref_src_i), .sel_i(ref_sel_i), .pol_i(ref_pol_i),
        .gen_mode_i(gen_mode_i), .lines_i(lines_i), .lines_prev_i(r_q.lines_prev),
        .match_i(match), .match_prev_i(r_q.match_prev),
        .fire_o(ref_fire), .off_o(ref_off)
    );

    assign pause_lvl = pause_fire & ~pause_off;

    pause_delay #(.DEPTH(PAUSE_LAT)) u_pdly (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (pause_lvl),
        .out_o (pause_late)
    );

    // capture pauses with the data, playback after a fixed lag
    assign pause_eff = gen_mode_i ? pause_late : pause_lvl;

    always_comb begin
        logic running;
        logic ref_ok;
        logic finish;

        r_d            = r_q;
        r_d.lines_prev = lines_i;
        r_d.match_prev = match;
        running        = (r_q.st == ST_RUN);
        ref_ok         = 1'b0;
        finish         = 1'b0;

        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (arm_i) r_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (start_off || start_fire) begin
                    r_d.st       = ST_RUN;
                    r_d.pre      = '0;
                    r_d.post     = '0;
                    r_d.ref_seen = 1'b0;
                end
            end
            ST_RUN, ST_PAUSE: begin
                ref_ok = !gen_mode_i && !ref_off && ref_fire && running &&
                         !r_q.ref_seen && (r_q.pre >= pre_count_i);
                if (running && !r_q.ref_seen && (r_q.pre != CNT_MAX))
                    r_d.pre = r_q.pre + 1'b1;
                if (ref_ok) begin
                    if (post_count_i == '0) begin
                        finish = 1'b1;
                    end else begin
                        r_d.post     = post_count_i;
                        r_d.ref_seen = 1'b1;
                    end
                end else if (running && r_q.ref_seen) begin
                    if (r_q.post == CNT_W'(1)) finish = 1'b1;
                    else                       r_d.post = r_q.post - 1'b1;
                end
                if (finish)         r_d.st = ST_DONE;
                else if (pause_eff) r_d.st = ST_PAUSE;
                else                r_d.st = ST_RUN;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (stop_i) r_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, lines_prev: '0, match_prev: 1'b0,
                     pre: '0, post: '0, ref_seen: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o       = r_q.st;
    assign ready_start_o = (r_q.st == ST_ARMED);
    assign data_active_o = (r_q.st == ST_RUN);
endmodule

// File: rtl/trig_engine_chk.sv
module trig_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm_i,
    input logic       stop_i,
    input logic       gen_mode_i,
    input logic [1:0] start_src_i,
    input logic [1:0] ref_src_i,
    input logic       pause_lvl,
    input logic [2:0] state_o
);
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_o == 3'd0)); // R11

    AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && arm_i && !stop_i) |=> (state_o == 3'd1)); // R2

    AST_GEN_PAT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && gen_mode_i && start_src_i[1] && !stop_i) |=> (state_o == 3'd2)); // R5

    AST_ACQ_PAUSE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_mode_i && state_o == 3'd2 && pause_lvl && !stop_i && ref_src_i == 2'd0)
        |=> (state_o == 3'd3)); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && !stop_i && !arm_i) |=> (state_o == 3'd4)); // R10

    AST_DONE_ONLY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> !$past(gen_mode_i)); // R9
endmodule

bind trig_engine trig_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .stop_i      (stop_i),
    .gen_mode_i  (gen_mode_i),
    .start_src_i (start_src_i),
    .ref_src_i   (ref_src_i),
    .pause_lvl   (pause_lvl),
    .state_o     (state_o)
);

// File: tb/trig_engine_tb.sv
`timescale 1ns/1ps
module trig_engine_tb;
    localparam int DW = 8;
    localparam int NL = 4;
    localparam int CW = 8;
    localparam int PL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 0, stop = 0, gen = 0;
    logic [NL-1:0] lines = '0;
    logic [DW-1:0] data = '0, pat = '0, mask = '0;
    logic [1:0] s_src = 0, p_src = 0, r_src = 0;
    logic [1:0] s_sel = 0, p_sel = 0, r_sel = 0;
    logic s_pol = 0, p_pol = 0, r_pol = 0;
    logic [CW-1:0] pre_n = 0, post_n = 0;
    logic [2:0] state;
    logic rdy, act;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;
    string cur = "R1";

    always #5 clk = ~clk;

    trig_engine #(.DATA_W(DW), .N_LINES(NL), .CNT_W(CW), .PAUSE_LAT(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .stop_i(stop), .gen_mode_i(gen),
        .lines_i(lines), .data_i(data), .pattern_i(pat), .mask_i(mask),
        .start_src_i(s_src), .start_sel_i(s_sel), .start_pol_i(s_pol),
        .pause_src_i(p_src), .pause_sel_i(p_sel), .pause_pol_i(p_pol),
        .ref_src_i(r_src), .ref_sel_i(r_sel), .ref_pol_i(r_pol),
        .pre_count_i(pre_n), .post_count_i(post_n),
        .state_o(state), .ready_start_o(rdy), .data_active_o(act)
    );

    // ---------------- behavioural reference model ----------------
    int m_st, m_pre, m_post;
    bit m_rs, m_mp;
    bit [NL-1:0] m_lp;
    bit pq[$];

    function automatic bit cond(int src, int sel, bit pol, bit [NL-1:0] ln, bit mt, bit g);
        case (src)
            1: return ln[sel] ^ pol;
            2: return g ? 1'b0 : mt;
            3: return g ? 1'b0 : !mt;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_pre = 0; m_post = 0; m_rs = 0; m_mp = 0; m_lp = '0;
            pq.delete();
            for (int i = 0; i < PL; i++) pq.push_back(1'b0);
        end else begin
            bit mt, s_e, r_e, s_off, pn, peff, run, ok, fin;
            int nst;
            mt    = (((data ^ pat) & mask) == 0);
            s_e   = cond(s_src, s_sel, s_pol, lines, mt, gen) && !cond(s_src, s_sel, s_pol, m_lp, m_mp, gen);
            r_e   = cond(r_src, r_sel, r_pol, lines, mt, gen) && !cond(r_src, r_sel, r_pol, m_lp, m_mp, gen);
            s_off = (s_src == 0) || (gen && s_src >= 2);
            pn    = cond(p_src, p_sel, p_pol, lines, mt, gen);
            if (PL == 0) peff = pn;
            else begin peff = pq[0]; void'(pq.pop_front()); pq.push_back(pn); end
            if (!gen) peff = pn;
            nst = m_st;
            if (m_st == 0 || m_st == 4) begin
                if (arm) nst = 1;
            end else if (m_st == 1) begin
                if (s_off || s_e) begin nst = 2; m_pre = 0; m_post = 0; m_rs = 0; end
            end else begin
                run = (m_st == 2);
                ok  = !gen && run && !m_rs && r_e && (m_pre >= pre_n);
                fin = 0;
                if (run && !m_rs && m_pre < (1 << CW) - 1) m_pre++;
                if (ok) begin
                    if (post_n == 0) fin = 1;
                    else begin m_post = post_n; m_rs = 1; end
                end else if (run && m_rs) begin
                    if (m_post == 1) fin = 1; else m_post--;
                end
                nst = fin ? 4 : (peff ? 3 : 2);
            end
            if (stop) nst = 0;
            m_st = nst; m_lp = lines; m_mp = mt;
        end
    end

    // ---------------- checking ----------------
    task automatic tick();
        @(negedge clk);
        n_checks++;
        if (state !== 3'(m_st)) begin
            n_fails++;
            $display("FAIL %s model state: actual=%0d expected=%0d", cur, state, m_st);
        end
        n_checks++;
        if (rdy !== (m_st == 1)) begin
            n_fails++;
            $display("FAIL R2 ready_start: actual=%0b expected=%0b", rdy, (m_st == 1));
        end
        n_checks++;
        if (act !== (m_st == 2)) begin
            n_fails++;
            $display("FAIL R8 data_active: actual=%0b expected=%0b", act, (m_st == 2));
        end
    endtask

    task automatic expect_st(int exp, string tag);
        n_checks++;
        if (state !== 3'(exp)) begin
            n_fails++;
            $display("FAIL %s state: actual=%0d expected=%0d", tag, state, exp);
        end
    endtask

    task automatic do_arm();
        arm = 1; tick(); arm = 0;
    endtask

    task automatic do_stop();
        stop = 1; tick(); stop = 0; expect_st(0, "R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        expect_st(0, "R1");
        n_checks++;
        if (rdy !== 0 || act !== 0) begin
            n_fails++;
            $display("FAIL R1 events: actual=%0b%0b expected=00", rdy, act);
        end

        // R3 rising edge on line 1
        cur = "R3"; s_src = 1; s_sel = 1; s_pol = 0;
        do_arm(); expect_st(1, "R2");
        tick(); tick(); expect_st(1, "R3");
        lines[1] = 1; tick(); expect_st(2, "R3");
        do_arm(); expect_st(2, "R2");
        do_stop(); lines = '0; tick();

        // R3 falling edge on line 2
        s_sel = 2; s_pol = 1; lines[2] = 1; tick();
        do_arm(); expect_st(1, "R2");
        tick(); expect_st(1, "R3");
        lines[2] = 0; tick(); expect_st(2, "R3");
        do_stop();

        // R3 start disabled
        s_src = 0;
        do_arm(); expect_st(1, "R3");
        tick(); expect_st(2, "R3");
        do_stop();

        // R4 masked match and mismatch
        cur = "R4"; pat = 8'hA5; mask = 8'hF0; s_src = 2; data = 8'h00; tick();
        do_arm(); expect_st(1, "R4");
        data = 8'h3A; tick(); expect_st(1, "R4");
        data = 8'hA3; tick(); expect_st(2, "R4");
        do_stop();
        s_src = 3; data = 8'hA0; tick();
        do_arm();
        data = 8'hA7; tick(); expect_st(1, "R4");
        data = 8'hB7; tick(); expect_st(2, "R4");
        do_stop(); data = 8'h00; tick();

        // R5 pattern start unavailable in playback
        cur = "R5"; gen = 1; s_src = 2;
        do_arm(); expect_st(1, "R5");
        tick(); expect_st(2, "R5");
        do_stop(); gen = 0; s_src = 0;

        // R6 capture pause, low active on line 0
        cur = "R6"; p_src = 1; p_sel = 0; p_pol = 1; lines[0] = 1; tick();
        do_arm(); tick(); tick(); expect_st(2, "R6");
        lines[0] = 0; tick(); expect_st(3, "R6");
        n_checks++;
        if (act !== 0) begin
            n_fails++;
            $display("FAIL R8 paused active: actual=%0b expected=0", act);
        end
        lines[0] = 1; tick(); expect_st(2, "R6");
        do_stop();

        // R7 playback pause lag
        cur = "R7"; gen = 1; p_pol = 0; lines[0] = 0; tick();
        do_arm(); tick(); tick(); expect_st(2, "R7");
        lines[0] = 1; tick(); expect_st(2, "R7");
        for (int i = 1; i < PL; i++) begin tick(); expect_st(2, "R7"); end
        tick(); expect_st(3, "R7");
        lines[0] = 0; tick(); expect_st(3, "R7");
        for (int i = 1; i < PL; i++) begin tick(); expect_st(3, "R7"); end
        tick(); expect_st(2, "R7");
        do_stop(); gen = 0; lines = '0; tick();

        // R9/R10 reference with pre and post counts
        cur = "R9"; p_pol = 0; r_src = 1; r_sel = 3; r_pol = 0; pre_n = 4; post_n = 3;
        do_arm(); tick(); expect_st(2, "R9");
        lines[3] = 1; tick(); lines[3] = 0; tick();
        tick(); tick(); tick(); expect_st(2, "R9");
        cur = "R10";
        lines[3] = 1; tick(); lines[3] = 0; expect_st(2, "R10");
        lines[0] = 1; tick(); tick(); expect_st(3, "R10");
        lines[0] = 0; tick(); expect_st(2, "R10");
        tick(); expect_st(2, "R10");
        tick(); expect_st(4, "R10");
        tick(); expect_st(4, "R10");
        do_arm(); expect_st(1, "R2");
        do_stop();

        // R10 zero post count ends on acceptance edge
        pre_n = 0; post_n = 0;
        do_arm(); tick();
        lines[3] = 1; tick(); lines[3] = 0; expect_st(4, "R10");
        do_stop();

        // R9 reference ignored in playback
        cur = "R9"; gen = 1; pre_n = 0; post_n = 1;
        do_arm(); tick();
        for (int i = 0; i < 4; i++) begin
            lines[3] = 1; tick(); lines[3] = 0; tick();
        end
        expect_st(2, "R9");
        do_stop(); gen = 0;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule